// File: doc/BRIEF.md
# Selectable GPIO Interrupt Channel Unit

This block turns a wide vector of GPIO pin interrupt lines into 32 interrupt channels. Each channel has its own source multiplexer. A 7-bit selector picks one pin line, and a per-channel enable gates it. A 2-bit sense field chooses rising edge, falling edge, high level or low level. The detection result is kept in a 32-bit status word.

Software programs the unit through a simple 32-bit register bus. The bus has a write strobe, a byte address and combinational read data. In the edge modes a flag stays latched until software writes a 1 to its bit in the clear register. In the level modes the flag tracks the selected input directly. Each of the 32 request outputs is high when the channel's status flag is set and the channel is enabled.

Top module: `gpio_irq_sel_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and all request outputs are 0.
- R2: The select register for channel t is at byte address 0x30 + 4*(t/4), in lane n = t%4. Bits 8n+6..8n hold the source index and bit 8n+7 is the channel enable. A written value reads back unchanged.
- R3: The sense register for channel t is at 0x28 + 4*(t/16), with a 2-bit field at bit 2*(t%16). The codes are 0 for rising edge, 1 for falling edge, 2 for high level and 3 for low level. A written value reads back unchanged.
- R4: In rising-edge mode, a 0-to-1 change of the selected input sets status bit t (read at 0x20) at the next clock. The bit stays set after the input falls.
- R5: In falling-edge mode, a 1-to-0 change of the selected input sets the status bit at the next clock.
- R6: In the level modes with the channel enabled, the status bit equals the selected input (high mode) or its inverse (low mode), one clock late.
- R7: Writing 0x24 clears each edge-mode status bit whose data bit is 1. Bits written with 0 are unchanged.
- R8: A clear write has no effect on a channel in a level mode.
- R9: A selector above 0x55 selects no source. The input counts as inactive, so no edge is detected and the status stays 0 in both level modes.
- R10: While a channel's enable is 0, no new detection sets its status bit and its request output is 0. An already-latched edge flag stays set and can still be cleared.
- R11: Each request output equals its status bit ANDed with its channel enable.
- R12: A change of a channel's selector or enable cannot create an edge in the clock that follows the change.
- R13: When a detected edge and a clear of the same bit occur in the same clock, the bit ends up set.
- R14: Writes to the status address 0x20 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gpio_in | input | 86 | GPIO pin interrupt lines, indices 0 to 0x55 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address, for both read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_req | output | 32 | Per-channel interrupt request |

## Verification
The assertions assume that gpio_in is already synchronous to clk and that each pin line is stable for a whole cycle. They also assume that each bus write lasts exactly one cycle with a stable address. The bench changes gpio_in and every bus signal only on the falling clock edge. Every write is a single-cycle pulse that returns the address to the status register, so both assumptions hold. Random selectors are biased toward a few toggling pins and toward the out-of-range values 0x56 and 0x7F, so that edges, level tracking and the no-source case all occur often.

// File: rtl/gisu_pkg.sv
// Shared constants and types of the selectable GPIO interrupt channel unit.
// Assumes byte addressing on a 32-bit register bus.
package gisu_pkg;
    typedef enum logic [1:0] {
        SNS_RISE = 2'd0,
        SNS_FALL = 2'd1,
        SNS_HIGH = 2'd2,
        SNS_LOW  = 2'd3
    } sense_e;

    localparam int STAT_ADDR = 'h20;
    localparam int CLR_ADDR  = 'h24;
    localparam int SNS_BASE  = 'h28;
    localparam int SEL_BASE  = 'h30;
    localparam int LANE_W    = 8;
    localparam int SNS_W     = 2;
endpackage

// File: rtl/gisu_regs.sv
// Register file: per-channel selector, enable and sense fields, clear pulses
// and read-back mux. It also flags each channel whose selector or enable has
// just changed, so that channel skips one edge check.
// Assumes NUM_CH is a multiple of 16 and that select lanes are SEL_W+1 <= 8 bits.
module gisu_regs
    import gisu_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int SEL_W  = 7,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_CH-1:0]             status,
    output logic [DATA_W-1:0]             rdata,
    output logic [NUM_CH-1:0][SEL_W-1:0]  sel_o,
    output logic [NUM_CH-1:0]             en_o,
    output logic [NUM_CH-1:0][SNS_W-1:0]  sense_o,
    output logic [NUM_CH-1:0]             rearm_o,
    output logic [NUM_CH-1:0]             clr_o
);
    localparam int LANES   = DATA_W / LANE_W;
    localparam int FIELDS  = DATA_W / SNS_W;

    // Clear pulses are the write data of a clear-register write.
    assign clr_o = (wr && addr == ADDR_W'(CLR_ADDR)) ? wdata[NUM_CH-1:0] : '0;

    for (genvar t = 0; t < NUM_CH; t++) begin : g_ch
        localparam int SEL_REG = SEL_BASE + 4 * (t / LANES);
        localparam int SNS_REG = SNS_BASE + 4 * (t / FIELDS);
        localparam int LO      = LANE_W * (t % LANES);
        localparam int SLO     = SNS_W * (t % FIELDS);

        logic             sel_hit, sns_hit;
        logic [SEL_W-1:0] sel_r, sel_new;
        logic             en_r, en_new, rearm_r;
        logic [SNS_W-1:0] sns_r;

        assign sel_hit = wr && addr == ADDR_W'(SEL_REG);
        assign sns_hit = wr && addr == ADDR_W'(SNS_REG);
        assign sel_new = wdata[LO +: SEL_W];
        assign en_new  = wdata[LO + LANE_W - 1];

        // Selector and enable storage plus the one-cycle re-arm flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_r   <= '0;
                en_r    <= 1'b0;
                rearm_r <= 1'b0;
            end else begin
                rearm_r <= sel_hit && (sel_new != sel_r || en_new != en_r);
                if (sel_hit) begin
                    sel_r <= sel_new;
                    en_r  <= en_new;
                end
            end
        end

        // Sense-mode storage.
        always_ff @(posedge clk) begin
            if (!rst_n)       sns_r <= '0;
            else if (sns_hit) sns_r <= wdata[SLO +: SNS_W];
        end

        assign sel_o[t]   = sel_r;
        assign en_o[t]    = en_r;
        assign sense_o[t] = sns_r;
        assign rearm_o[t] = rearm_r;
    end

    // Read-back mux for the status, select and sense registers.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(STAT_ADDR)) rdata[NUM_CH-1:0] = status;
        for (int t = 0; t < NUM_CH; t++) begin
            if (addr == ADDR_W'(SEL_BASE + 4 * (t / LANES)))
                rdata[LANE_W*(t%LANES) +: LANE_W] = {en_o[t], sel_o[t]};
            if (addr == ADDR_W'(SNS_BASE + 4 * (t / FIELDS)))
                rdata[SNS_W*(t%FIELDS) +: SNS_W] = sense_o[t];
        end
    end
endmodule

// File: rtl/gisu_chan.sv
// One interrupt channel: picks a source line, detects the programmed edge or
// level, and keeps the status flag. Assumes the source lines are synchronous to clk.
module gisu_chan
    import gisu_pkg::*;
#(
    parameter int NUM_SRC = 86,
    parameter int SEL_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_vec,
    input  logic [SEL_W-1:0]   sel,
    input  logic               en,
    input  logic [SNS_W-1:0]   sense,
    input  logic               rearm,
    input  logic               clr,
    output logic               status
);
    localparam logic [SEL_W-1:0] MAX_IDX = SEL_W'(NUM_SRC - 1);

    logic             sel_ok, src, hist, evt, lvl, edge_mode;
    logic [SEL_W-1:0] idx;

    assign sel_ok    = sel <= MAX_IDX;
    assign idx       = sel_ok ? sel : '0;
    assign src       = sel_ok & src_vec[idx];
    assign edge_mode = (sense == SNS_RISE) || (sense == SNS_FALL);
    assign evt       = en && !rearm &&
                       ((sense == SNS_RISE) ? (src & ~hist) : (~src & hist));
    assign lvl       = sel_ok & ((sense == SNS_HIGH) ? src : ~src);

    // Remember the selected input for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= 1'b0;
        else        hist <= src;
    end

    // Status flag: edge latch with clear, or level tracking while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)             status <= 1'b0;
        else if (edge_mode) begin
            if (evt)            status <= 1'b1;
            else if (clr)       status <= 1'b0;
        end else if (en)        status <= lvl;
    end

    // R10: a flag only rises when the channel was enabled.
    p_set_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !$past(status)) |-> $past(en));
    // R12: no edge is taken the cycle after reprogramming.
    p_no_false_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rearm) && !$past(sense[1]) && !$past(status)) |-> !status);
    // R8: clear does not touch a level-mode flag.
    p_clr_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sense[1] && clr && status && !en) |-> status);
    // R7: clear drops an edge flag when no new detection can occur.
    p_clr_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sense[1] && clr && status && !en) |-> !status);
    // R9: an out-of-range selector never asserts a level flag.
    p_bad_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && sense[1] && (sel > MAX_IDX)) |-> !status);
endmodule

// File: rtl/gpio_irq_sel_unit.sv
// Top of the selectable GPIO interrupt channel unit: a register file and one
// channel per request output. Assumes single-cycle bus writes and synchronous inputs.
module gpio_irq_sel_unit
    import gisu_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_SRC = 86,
    parameter int SEL_W   = 7,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] gpio_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0]  irq_req
);
    logic [NUM_CH-1:0][SEL_W-1:0] sel;
    logic [NUM_CH-1:0][SNS_W-1:0] sense;
    logic [NUM_CH-1:0]            en, rearm, clr, status;

    gisu_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .status(status), .rdata(bus_rdata), .sel_o(sel), .en_o(en),
        .sense_o(sense), .rearm_o(rearm), .clr_o(clr)
    );

    for (genvar t = 0; t < NUM_CH; t++) begin : g_chan
        gisu_chan #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) chan_i (
            .clk(clk), .rst_n(rst_n), .src_vec(gpio_in), .sel(sel[t]), .en(en[t]),
            .sense(sense[t]), .rearm(rearm[t]), .clr(clr[t]), .status(status[t])
        );
    end

    // Requests are the latched flags of enabled channels.
    assign irq_req = status & en;
endmodule

// File: tb/gpio_irq_sel_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_sel_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [85:0] gpio = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h20;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_req;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gpio_irq_sel_unit dut_i (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req)
    );

    // Reference model built from the requirements.
    logic [6:0]  m_sel [32];
    logic        m_en [32];
    logic [1:0]  m_sns [32];
    logic [31:0] m_stat;
    logic [31:0] m_hist;
    logic [31:0] m_rearm;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 32; t++) begin
                m_sel[t] <= '0; m_en[t] <= 1'b0; m_sns[t] <= '0;
            end
            m_stat <= '0; m_hist <= '0; m_rearm <= '0;
        end else begin
            for (int t = 0; t < 32; t++) begin
                logic ok, s, ev, clr, hit;
                logic [6:0] nsel;
                logic nen;
                ok  = m_sel[t] <= 7'h55;
                s   = ok ? gpio[m_sel[t]] : 1'b0;
                ev  = m_en[t] && !m_rearm[t] &&
                      ((m_sns[t] == 2'd0) ? (s && !m_hist[t]) : (!s && m_hist[t]));
                clr = bus_wr && bus_addr == 8'h24 && bus_wdata[t];
                if (m_sns[t][1] == 1'b0) begin
                    if (ev)       m_stat[t] <= 1'b1;
                    else if (clr) m_stat[t] <= 1'b0;
                end else if (m_en[t]) begin
                    m_stat[t] <= ok && ((m_sns[t] == 2'd2) ? s : !s);
                end
                m_hist[t] <= s;
                hit  = bus_wr && bus_addr == 8'(8'h30 + 4 * (t / 4));
                nsel = bus_wdata[8*(t%4) +: 7];
                nen  = bus_wdata[8*(t%4) + 7];
                m_rearm[t] <= hit && (nsel != m_sel[t] || nen != m_en[t]);
                if (hit) begin m_sel[t] <= nsel; m_en[t] <= nen; end
                if (bus_wr && bus_addr == 8'(8'h28 + 4 * (t / 16)))
                    m_sns[t] <= bus_wdata[2*(t%16) +: 2];
            end
        end
    end

    function automatic logic [31:0] exp_sel_reg(int k);
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) v[8*n +: 8] = {m_en[4*k+n], m_sel[4*k+n]};
        return v;
    endfunction

    function automatic logic [31:0] exp_sns_reg(int k);
        logic [31:0] v = '0;
        for (int n = 0; n < 16; n++) v[2*n +: 2] = m_sns[16*k+n];
        return v;
    endfunction

    function automatic logic [31:0] exp_req();
        logic [31:0] v;
        for (int t = 0; t < 32; t++) v[t] = m_stat[t] & m_en[t];
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one clock, then compare status and requests with the model.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        check("R11 irq_req", irq_req, exp_req());
        if (bus_addr == 8'h20) check("R4 status", bus_rdata, m_stat);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0; bus_addr = 8'h20; bus_wdata = '0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_addr = 8'h20;
        #1;
    endtask

    task automatic bit_chk(string tag, int idx, logic exp);
        #1;
        check(tag, 32'(bus_rdata[idx]), 32'(exp));
    endtask

    function automatic logic [7:0] rnd_lane();
        int r = $urandom_range(0, 9);
        logic [6:0] s = (r < 7) ? 7'($urandom_range(0, 7)) :
                        (r == 7) ? 7'h55 : (r == 8) ? 7'h56 : 7'h7F;
        return {1'($urandom_range(0, 1)), s};
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1 req", irq_req, '0);
        rd_chk("R1 status", 8'h20, '0);
        for (int k = 0; k < 2; k++) rd_chk("R1 sense", 8'(8'h28 + 4*k), '0);
        for (int k = 0; k < 8; k++) rd_chk("R1 select", 8'(8'h30 + 4*k), '0);

        // R12: select a line that is already high; no false edge.
        gpio[8'h10] = 1'b1;
        wr(8'h34, 32'h0000_9000);
        rd_chk("R2 select readback", 8'h34, 32'h0000_9000);
        cyc();
        bit_chk("R12 no false edge", 5, 1'b0);
        // R4: rising edge latches.
        gpio[8'h10] = 1'b0; cyc();
        gpio[8'h10] = 1'b1; cyc();
        bit_chk("R4 rise set", 5, 1'b1);
        check("R11 req ch5", 32'(irq_req[5]), 32'd1);
        gpio[8'h10] = 1'b0; cyc();
        bit_chk("R4 held after fall", 5, 1'b1);
        // R7: clear with a zero bit, then with the bit.
        wr(8'h24, 32'h0000_0040);
        bit_chk("R7 zero bit keeps", 5, 1'b1);
        wr(8'h24, 32'h0000_0020);
        bit_chk("R7 clear", 5, 1'b0);
        // R13: edge and clear in the same cycle.
        gpio[8'h10] = 1'b1; cyc();
        gpio[8'h10] = 1'b0; cyc();
        gpio[8'h10] = 1'b1;
        wr(8'h24, 32'h0000_0020);
        bit_chk("R13 set wins", 5, 1'b1);
        // R14: status address is read-only.
        wr(8'h20, 32'hFFFF_FFFF);
        rd_chk("R14 status unchanged", 8'h20, 32'h0000_0020);
        // R10: disable masks request, keeps flag, blocks detection.
        wr(8'h34, 32'h0000_1000);
        check("R10 req masked", 32'(irq_req[5]), 32'd0);
        bit_chk("R10 flag kept", 5, 1'b1);
        wr(8'h24, 32'h0000_0020);
        gpio[8'h10] = 1'b0; cyc();
        gpio[8'h10] = 1'b1; cyc();
        bit_chk("R10 no detect", 5, 1'b0);
        // R5: falling edge.
        wr(8'h28, 32'h0000_0400);
        rd_chk("R3 sense readback", 8'h28, 32'h0000_0400);
        wr(8'h34, 32'h0000_9000);
        cyc();
        gpio[8'h10] = 1'b0; cyc();
        bit_chk("R5 fall set", 5, 1'b1);
        // R6/R8: channel 20 in high-level mode on line 0x55.
        wr(8'h44, 32'h0000_00D5);
        wr(8'h2C, 32'h0000_0200);
        gpio[85] = 1'b1; cyc();
        bit_chk("R6 high level", 20, 1'b1);
        wr(8'h24, 32'h0010_0000);
        bit_chk("R8 clear ignored", 20, 1'b1);
        gpio[85] = 1'b0; cyc();
        bit_chk("R6 level follows", 20, 1'b0);
        wr(8'h2C, 32'h0000_0300);
        cyc();
        bit_chk("R6 low level", 20, 1'b1);
        // R9: out-of-range selector.
        wr(8'h44, 32'h0000_00D6);
        cyc();
        bit_chk("R9 bad select low mode", 20, 1'b0);
        gpio[85] = 1'b1; cyc();
        bit_chk("R9 bad select ignores line", 20, 1'b0);

        // Random phase checked against the model.
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            gpio[7:0] = gpio[7:0] ^ 8'($urandom_range(0, 255) & $urandom_range(0, 255));
            gpio[85]  = 1'($urandom_range(0, 1));
            if (r < 8) begin
                wr(8'(8'h28 + 4 * $urandom_range(0, 1)), $urandom());
            end else if (r < 18) begin
                wr(8'(8'h30 + 4 * $urandom_range(0, 7)),
                   {rnd_lane(), rnd_lane(), rnd_lane(), rnd_lane()});
            end else if (r < 28) begin
                wr(8'h24, $urandom());
            end else if (r < 31) begin
                int k = $urandom_range(0, 7);
                rd_chk("R2 select random", 8'(8'h30 + 4*k), exp_sel_reg(k));
                rd_chk("R3 sense random", 8'(8'h28 + 4*(k%2)), exp_sns_reg(k%2));
            end else begin
                cyc();
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule